// File: doc/BRIEF.md
# Four-Slot Word-Serial Descriptor Queue

This block queues transfer descriptors for a single DMA channel. Software builds each descriptor by writing four 32-bit words, one after another, to one push register. The words arrive in a fixed order: the low half of the buffer address, the high half, the byte length, and then a flags word. A small state machine counts the words as they arrive. Only the fourth word commits the descriptor into one of four storage slots.

The transfer engine sees the oldest stored descriptor on parallel outputs whenever the queue holds at least one entry. It retires that descriptor with a one-cycle pop request. A read-only status word reports both slot pointers together with the empty, full and sticky error flags. Software clears the error flag by writing one to its bit position. A hold bit in a control register clears the queue and keeps it cleared until software writes the bit back to zero.

The assembly state machine has four states: `ST_ADDR_LO`, `ST_ADDR_HI`, `ST_LENGTH` and `ST_FLAGS`. Each accepted push word moves it to the next state in that order. From `ST_FLAGS`, an accepted word returns it to `ST_ADDR_LO` and raises the commit pulse. A ring clear moves it from any state straight back to `ST_ADDR_LO`.

Top module: `desc_ring_queue`

## Requirements
- R1: After reset, the status word reads 0x100: both pointers are zero, only the empty flag is set and the error flag is clear. `desc_valid` is low.
- R2: Register writes use `reg_sel` to pick the target: 0 is the push register, 1 the status word, 2 the control register. Push words are taken in the order address low, address high, length, flags. The write pointer advances on the clock edge that accepts the fourth word and not before.
- R3: While the queue is not empty, `desc_valid` is high and the outputs show the oldest descriptor. `desc_addr` is {address high, address low}, `desc_len` is the length word and `desc_flags` is the flags word. `desc_notify` equals bit 16 of the flags word.
- R4: The status word places the write pointer in bits [1:0], the read pointer in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10. All other bits read zero.
- R5: The queue holds four descriptors. When the two pointers are equal, exactly one of full or empty is set. Otherwise neither flag is set and the occupancy is (write − read) mod 4.
- R6: A descriptor completed while the queue is full is dropped. The error flag is set, and the pointers and the head descriptor stay unchanged.
- R7: A pop request while the queue is empty changes no pointer and sets the error flag.
- R8: A pop request on a non-empty queue advances the read pointer by one, modulo 4. After that pop the full flag is clear.
- R9: The error flag stays set until a status write has bit 10 set. A status write with bit 10 clear leaves the flag unchanged. If an error event happens in the same cycle as a clearing write, the flag stays set.
- R10: Writing a control word with bit 0 set clears both pointers, the occupancy and any partly assembled descriptor on that same edge. While the hold bit is set, push words and pop requests are ignored and raise no error. Writing bit 0 as zero releases the hold from the next cycle.
- R11: Descriptors leave the queue in the order they were completed, including when the pointers wrap past slot 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 push, 1 status, 2 control |
| reg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Pointers and flags |
| pop_req | input | 1 | Consumer retires the head descriptor |
| desc_valid | output | 1 | Head descriptor present |
| desc_addr | output | 64 | Head buffer address |
| desc_len | output | 32 | Head length in bytes |
| desc_flags | output | 32 | Head flags word |
| desc_notify | output | 1 | Head requests completion notice |

## Verification
All register and pop effects take one clock edge. The status word and the head outputs change on the same edge that accepts the fourth push word, the pop, the status write or the control write. Their new values are visible for the whole following cycle. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares the outputs at the next falling edge, so every comparison lands exactly one edge after its cause. Partial descriptors are checked on each of their first three words, to show that nothing changes until the fourth word arrives.

// File: rtl/dq_pkg.sv
`timescale 1ns/1ps
package dq_pkg;
    localparam int WORD_W = 32;

    // write target select codes
    localparam logic [1:0] SEL_PUSH = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // status word layout
    localparam int WR_LSB     = 0;
    localparam int RD_LSB     = 4;
    localparam int EMPTY_BIT  = 8;
    localparam int FULL_BIT   = 9;
    localparam int ERR_BIT    = 10;
    localparam int NOTIFY_BIT = 16;
    localparam int HOLD_BIT   = 0;

    typedef enum logic [1:0] {
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_LENGTH,
        ST_FLAGS
    } asm_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr_hi;
        logic [WORD_W-1:0] addr_lo;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] flags;
    } desc_t;
endpackage

// File: rtl/dq_assembler.sv
`timescale 1ns/1ps
module dq_assembler
    import dq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_in,
    output desc_t             desc_out,
    output logic              desc_done
);
    asm_state_e state_q, state_d;
    logic [WORD_W-1:0] lo_q, hi_q, len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        desc_done = 1'b0;
        if (clr) begin
            state_d = ST_ADDR_LO;
        end else if (word_we) begin
            unique case (state_q)
                ST_ADDR_LO: state_d = ST_ADDR_HI;
                ST_ADDR_HI: state_d = ST_LENGTH;
                ST_LENGTH:  state_d = ST_FLAGS;
                ST_FLAGS: begin
                    state_d   = ST_ADDR_LO;
                    desc_done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            len_q <= '0;
        end else if (word_we && !clr) begin
            case (state_q)
                ST_ADDR_LO: lo_q  <= word_in;
                ST_ADDR_HI: hi_q  <= word_in;
                ST_LENGTH:  len_q <= word_in;
                default:    ;
            endcase
        end
    end

    always_comb begin
        desc_out.addr_hi = hi_q;
        desc_out.addr_lo = lo_q;
        desc_out.len     = len_q;
        desc_out.flags   = word_in;
    end
endmodule

// File: rtl/dq_slot_store.sv
`timescale 1ns/1ps
module dq_slot_store
    import dq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  desc_t            wdata,
    input  logic [PTR_W-1:0] raddr,
    output desc_t            rdata
);
    desc_t            mem [DEPTH];
    logic [DEPTH-1:0] slot_hit;

    for (genvar s = 0; s < DEPTH; s++) begin : g_sel
        assign slot_hit[s] = we && (waddr == PTR_W'(s));
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (slot_hit[s]) mem[s] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dq_ptr_ctrl.sv
`timescale 1ns/1ps
module dq_ptr_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic             err_clr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty,
    output logic             err,
    output logic             push_ok
);
    logic [CNT_W-1:0] count_q;
    logic             pop_ok, err_set;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign err_set = !clr && ((push && full) || (pop && empty));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else if (clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err <= 1'b0;
        else if (err_set) err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end
endmodule

// File: rtl/desc_ring_queue.sv
`timescale 1ns/1ps
module desc_ring_queue
    import dq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] status_word,
    input  logic        pop_req,
    output logic        desc_valid,
    output logic [63:0] desc_addr,
    output logic [31:0] desc_len,
    output logic [31:0] desc_flags,
    output logic        desc_notify
);
    logic             hold_q, ring_clr, ctrl_we, stat_we, push_we, err_clr;
    logic             push_done, push_ok, full, empty, err;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    desc_t            new_desc, head_desc;

    assign ctrl_we  = reg_we && (reg_sel == SEL_CTRL);
    assign stat_we  = reg_we && (reg_sel == SEL_STAT);
    assign ring_clr = hold_q || (ctrl_we && reg_wdata[HOLD_BIT]);
    assign push_we  = reg_we && (reg_sel == SEL_PUSH) && !ring_clr;
    assign err_clr  = stat_we && reg_wdata[ERR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= 1'b0;
        else if (ctrl_we) hold_q <= reg_wdata[HOLD_BIT];
    end

    dq_assembler u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ring_clr),
        .word_we   (push_we),
        .word_in   (reg_wdata),
        .desc_out  (new_desc),
        .desc_done (push_done)
    );

    dq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ring_clr),
        .push    (push_done),
        .pop     (pop_req),
        .err_clr (err_clr),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .full    (full),
        .empty   (empty),
        .err     (err),
        .push_ok (push_ok)
    );

    dq_slot_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (new_desc),
        .raddr (rd_ptr),
        .rdata (head_desc)
    );

    always_comb begin
        status_word                     = '0;
        status_word[WR_LSB +: PTR_W]    = wr_ptr;
        status_word[RD_LSB +: PTR_W]    = rd_ptr;
        status_word[EMPTY_BIT]          = empty;
        status_word[FULL_BIT]           = full;
        status_word[ERR_BIT]            = err;
    end

    assign desc_valid  = !empty;
    assign desc_addr   = {head_desc.addr_hi, head_desc.addr_lo};
    assign desc_len    = head_desc.len;
    assign desc_flags  = head_desc.flags;
    assign desc_notify = head_desc.flags[NOTIFY_BIT];
endmodule

// File: rtl/dq_checker.sv
`timescale 1ns/1ps
module dq_checker #(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_done,
    input logic             pop_req,
    input logic             ring_clr,
    input logic             err_clr,
    input logic             full,
    input logic             empty,
    input logic             err,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr
);
    // R5
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R5
    ptr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != rd_ptr) |-> (!full && !empty));

    // R6
    full_push_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_done && full && !ring_clr && !pop_req) |=> (err && $stable(wr_ptr) && full));

    // R7
    empty_pop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !ring_clr) |=> (err && $stable(rd_ptr)));

    // R8
    pop_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty && !ring_clr) |=>
            ((rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)) && !full));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !ring_clr && !(pop_req && empty) && !(push_done && full)) |=> !err);

    // R10
    ring_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_clr |=> (empty && wr_ptr == '0 && rd_ptr == '0));

    // R2
    partial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_done && !ring_clr) |=> $stable(wr_ptr));
endmodule

bind desc_ring_queue dq_checker #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_done (push_done),
    .pop_req   (pop_req),
    .ring_clr  (ring_clr),
    .err_clr   (err_clr),
    .full      (full),
    .empty     (empty),
    .err       (err),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/tb_desc_ring_queue.sv
`timescale 1ns/1ps
module tb_desc_ring_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        pop_req = 1'b0;
    logic [31:0] status_word;
    logic        desc_valid, desc_notify;
    logic [63:0] desc_addr;
    logic [31:0] desc_len, desc_flags;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    desc_ring_queue dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .status_word(status_word), .pop_req(pop_req),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_len(desc_len),
        .desc_flags(desc_flags), .desc_notify(desc_notify)
    );

    // ops: 0 push word, 1 pop, 2 status write, 3 control write
    // entry: {op[3:0], data[31:0], expected status[11:0]}
    localparam int NVEC = 21;
    localparam logic [47:0] VEC [NVEC] = '{
        {4'd0, 32'h0000_1000, 12'h100},  // R2 word 1 no advance
        {4'd0, 32'h0000_0000, 12'h100},  // R2 word 2
        {4'd0, 32'h0000_0040, 12'h100},  // R2 word 3
        {4'd0, 32'h0001_0000, 12'h001},  // R2 word 4 commits
        {4'd1, 32'h0,         12'h111},  // R8 pop
        {4'd1, 32'h0,         12'h511},  // R7 pop on empty
        {4'd2, 32'h0000_0000, 12'h511},  // R9 bit10 clear keeps error
        {4'd2, 32'h0000_0400, 12'h111},  // R9 clear error
        {4'd0, 32'h0000_2000, 12'h111},
        {4'd0, 32'h0000_0000, 12'h111},
        {4'd0, 32'h0000_0080, 12'h111},
        {4'd0, 32'h0000_0000, 12'h012},  // R4 wr=2 rd=1
        {4'd0, 32'h0000_3000, 12'h012},  // partial word before clear
        {4'd3, 32'h0000_0001, 12'h100},  // R10 clear same edge
        {4'd0, 32'h0000_4000, 12'h100},  // R10 push ignored in hold
        {4'd1, 32'h0,         12'h100},  // R10 pop ignored, no error
        {4'd3, 32'h0000_0000, 12'h100},  // R10 release
        {4'd0, 32'hA000_0000, 12'h100},  // R10 partial count restarted
        {4'd0, 32'h0000_0001, 12'h100},
        {4'd0, 32'h0000_0200, 12'h100},
        {4'd0, 32'h0001_0000, 12'h001}
    };

    task automatic drive(input int op, input logic [31:0] data);
        reg_we    = (op == 0 || op == 2 || op == 3);
        reg_sel   = (op == 2) ? 2'd1 : (op == 3) ? 2'd2 : 2'd0;
        reg_wdata = data;
        pop_req   = (op == 1);
        @(posedge clk);
        @(negedge clk);
        reg_we  = 1'b0;
        pop_req = 1'b0;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_desc(input logic [31:0] lo, hi, len, fl);
        drive(0, lo); drive(0, hi); drive(0, len); drive(0, fl);
    endtask

    task automatic chk_head(input string req, input logic [31:0] lo, hi, len, fl);
        chk(req, {63'b0, desc_valid}, 64'd1);
        chk(req, desc_addr, {hi, lo});
        chk(req, {32'b0, desc_len}, {32'b0, len});
        chk(req, {32'b0, desc_flags}, {32'b0, fl});
        chk(req, {63'b0, desc_notify}, {63'b0, fl[16]});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", {32'b0, status_word}, 64'h100);
        chk("R1", {63'b0, desc_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            drive(int'(VEC[i][47:44]), VEC[i][43:12]);
            chk($sformatf("R2/R4 vec%0d", i), {32'b0, status_word}, {52'b0, VEC[i][11:0]});
        end

        // R3 head shows first descriptor
        chk_head("R3", 32'hA000_0000, 32'h1, 32'h200, 32'h0001_0000);

        // R5 fill: wrap of write pointer, full with equal pointers
        push_desc(32'hB0, 32'h2, 32'h300, 32'h0);
        chk("R5 occ2", {32'b0, status_word}, 64'h002);
        push_desc(32'hC0, 32'h3, 32'h400, 32'h0001_0000);
        chk("R5 occ3", {32'b0, status_word}, 64'h003);
        push_desc(32'hD0, 32'h4, 32'h500, 32'h5);
        chk("R5 full", {32'b0, status_word}, 64'h200);

        // R6 push while full dropped
        push_desc(32'hE0, 32'h5, 32'h600, 32'h0001_0000);
        chk("R6", {32'b0, status_word}, 64'h600);
        chk_head("R6", 32'hA000_0000, 32'h1, 32'h200, 32'h0001_0000);
        drive(2, 32'h400);
        chk("R9", {32'b0, status_word}, 64'h200);

        // R8/R11 drain in order across wrap
        drive(1, 0);
        chk("R8", {32'b0, status_word}, 64'h010);
        chk_head("R11", 32'hB0, 32'h2, 32'h300, 32'h0);
        drive(1, 0);
        chk("R8", {32'b0, status_word}, 64'h020);
        chk_head("R11", 32'hC0, 32'h3, 32'h400, 32'h0001_0000);
        drive(1, 0);
        chk("R8", {32'b0, status_word}, 64'h030);
        chk_head("R11", 32'hD0, 32'h4, 32'h500, 32'h5);
        drive(1, 0);
        chk("R8", {32'b0, status_word}, 64'h100);
        chk("R3", {63'b0, desc_valid}, 64'd0);

        // R9 error set wins over same-cycle clear
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h400; pop_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; pop_req = 1'b0;
        chk("R9 set priority", {32'b0, status_word}, 64'h500);
        drive(2, 32'h400);
        chk("R9", {32'b0, status_word}, 64'h100);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule